// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the register front end of a serial port. A processor reaches it through a simple single-cycle bus with separate read and write strobes and a byte offset. The block decodes that offset inside a 0x28-byte window. It stores the line mode, bit-rate divisor, control, transmit data, FIFO control and port registers, and drives them out to the baud generator and shifter that sit beside it. It also keeps five status flags: transmit end, transmit data empty, break, receive FIFO full and data ready.

Software writes a byte to the transmit-data offset. The block then hands that byte to the shifter on a one-cycle strobe and clears transmit-data-empty. To clear a status flag, software writes a zero to its bit. Reading the status register while transmit is enabled re-arms both transmit flags. The receive side shows only a byte count, which comes in from the receive datapath. Three event inputs from that datapath set the break, FIFO-full and data-ready flags.

A build-time parameter selects the FIFO variant. That choice changes the write masks, the data-register reset value, and which offsets exist. Every output is registered, so the response to an access appears one clock after the strobe.

Top module: `sercfg_regs`

## Requirements
- R1: After reset the register values are as follows. Mode, control, port and FIFO control are 0x00. Bit rate is 0xFF. Transmit end and transmit data empty are 1, and break, FIFO full and data ready are 0. The transmit-data register is 0xFF without the FIFO variant and 0x00 with it.
- R2: The offset map is: 0x00 mode, 0x04 bit rate, 0x08 control, 0x0C transmit data, 0x10 status, 0x18 FIFO control, 0x1C receive count (read only), 0x20 port, 0x24 line status. Line status reads 0x00, and writes to it are accepted with no effect. The offsets 0x10 through 0x24 exist only in the FIFO variant. Each read returns its data on `rd_data`, with `rd_valid` high, one cycle after `rd_en`.
- R3: With the FIFO variant, a mode write keeps `wr_data & 0x7B` and a control write keeps `wr_data & 0xFB`. Without it, all eight bits are kept.
- R4: A control write whose bit 5 (transmit enable) is 0 sets transmit end.
- R5: A transmit-data write does three things. It stores the byte, so that a read of 0x0C returns it. It raises `tx_strobe` for one cycle, one cycle later, with `tx_byte` equal to the byte. It clears transmit data empty.
- R6: The status byte places transmit end at bit 6, transmit data empty at bit 5, break at bit 4, FIFO full at bit 1 and data ready at bit 0. Bits 7, 3 and 2 read 0.
- R7: A status write clears every flag whose bit is written as 0. A flag whose bit is written as 1 keeps its value.
- R8: A status read returns the flags as they stood before the read. If control bit 5 is 1, transmit end and transmit data empty are both 1 in the following cycle.
- R9: A pulse on `ev_brk`, `ev_rx_full` or `ev_rx_ready` sets break, FIFO full or data ready respectively. The set wins over a status-write clear in the same cycle.
- R10: Some accesses are errors: an offset with nonzero low two bits, an offset outside the map, 0x14, a write to 0x1C, or any FIFO-only offset when the FIFO variant is off. An error raises `acc_err` for one cycle, one cycle after the strobe, and changes no state. An erroneous read returns 0xFF.
- R11: A read of 0x1C returns `rx_count` zero-extended to eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W | Byte offset of the access |
| wr_data | input | 8 | Write data |
| rx_count | input | CNT_W | Receive byte count from the receive datapath |
| ev_brk | input | 1 | Break detected, sets break flag |
| ev_rx_full | input | 1 | Receive FIFO reached its trigger, sets FIFO-full flag |
| ev_rx_ready | input | 1 | Receive data waiting, sets data-ready flag |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | `rd_data` holds the result of the previous cycle's read |
| acc_err | output | 1 | Previous cycle's access was illegal |
| tx_strobe | output | 1 | One-cycle transmit request |
| tx_byte | output | 8 | Byte to transmit |
| mode_o | output | 8 | Stored line mode |
| rate_o | output | 8 | Stored bit-rate divisor |
| ctrl_o | output | 8 | Stored control byte |
| fifo_ctl_o | output | 8 | Stored FIFO control |
| port_o | output | 8 | Stored port register |

## Verification
The properties assume that `rd_en` and `wr_en` are never high together. When both are high, the block treats the access as a write, and the read-side properties would no longer describe it. They also assume that `rx_count` never exceeds eight bits. The stimulus, both directed and random, makes each access either a read, a write or an idle cycle, and never both. It drives the event pulses independently of the bus strobes, so an event can coincide with a status write. Illegal, misaligned and FIFO-only offsets are mixed into the random traffic so that the error path and its "no state change" rule are exercised against the legal path.

// File: rtl/sercfg_pkg.sv
// Package: shared types and constants for the serial register block.
// Assumes an 8-bit data path; offsets are byte offsets.
package sercfg_pkg;

    localparam int DW       = 8;
    localparam int TXEN_BIT = 5;

    // Decoded register target of one access
    typedef enum logic [3:0] {
        SEL_MODE, SEL_RATE, SEL_CTRL, SEL_TXD, SEL_STAT,
        SEL_FCTL, SEL_RXC, SEL_PORT, SEL_LSR, SEL_NONE
    } sel_e;

    // Status flags, packed high to low: tend, tde, brk, rdf, dr
    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rdf;
        logic dr;
    } flags_t;

    // Place the flags at their bit positions in the status byte
    function automatic logic [DW-1:0] pack_status(flags_t f);
        return {1'b0, f.tend, f.tde, f.brk, 2'b00, f.rdf, f.dr};
    endfunction

    // Mode write mask for the selected variant
    function automatic logic [DW-1:0] mode_mask(bit fifo);
        return fifo ? 8'h7B : 8'hFF;
    endfunction

    // Control write mask for the selected variant
    function automatic logic [DW-1:0] ctrl_mask(bit fifo);
        return fifo ? 8'hFB : 8'hFF;
    endfunction

endpackage

// File: rtl/sercfg_decode.sv
// Module: offset decoder. Maps a byte offset to one register target, or
// SEL_NONE for misaligned, unmapped, read-only-on-write and FIFO-only
// offsets when the FIFO variant is off. Purely combinational.
module sercfg_decode
    import sercfg_pkg::*;
#(
    parameter bit FIFO_EN = 1'b1,
    parameter int ADDR_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_wr,
    output sel_e              sel
);

    // Decode offset into a register select
    always_comb begin
        sel = SEL_NONE;
        case (addr)
            ADDR_W'('h00): sel = SEL_MODE;
            ADDR_W'('h04): sel = SEL_RATE;
            ADDR_W'('h08): sel = SEL_CTRL;
            ADDR_W'('h0C): sel = SEL_TXD;
            ADDR_W'('h10): sel = FIFO_EN ? SEL_STAT : SEL_NONE;
            ADDR_W'('h18): sel = FIFO_EN ? SEL_FCTL : SEL_NONE;
            ADDR_W'('h1C): sel = (FIFO_EN && !is_wr) ? SEL_RXC : SEL_NONE;
            ADDR_W'('h20): sel = FIFO_EN ? SEL_PORT : SEL_NONE;
            ADDR_W'('h24): sel = FIFO_EN ? SEL_LSR : SEL_NONE;
            default:       sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/sercfg_flags.sv
// Module: the five status flags. Applies, in order: control-write
// transmit-end set, transmit-write empty clear, status-write clears,
// status-read re-arm, then datapath event sets (events win).
// Assumes at most one bus access per cycle.
module sercfg_flags
    import sercfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ctrl_wr,
    input  logic   ctrl_txen_new,
    input  logic   txd_wr,
    input  logic   stat_wr,
    input  flags_t stat_keep,
    input  logic   stat_rd,
    input  logic   txen,
    input  logic   ev_brk,
    input  logic   ev_rdf,
    input  logic   ev_dr,
    output flags_t flags_q
);

    flags_t flags_d;

    // Next-state of the flags from this cycle's access and events
    always_comb begin
        flags_d = flags_q;
        if (ctrl_wr && !ctrl_txen_new) flags_d.tend = 1'b1;
        if (txd_wr)                    flags_d.tde  = 1'b0;
        if (stat_wr)                   flags_d      = flags_q & stat_keep;
        if (stat_rd && txen) begin
            flags_d.tend = 1'b1;
            flags_d.tde  = 1'b1;
        end
        if (ev_brk) flags_d.brk = 1'b1;
        if (ev_rdf) flags_d.rdf = 1'b1;
        if (ev_dr)  flags_d.dr  = 1'b1;
    end

    // Flag register with reset to both transmit flags set
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
        else        flags_q <= flags_d;
    end

endmodule

// File: rtl/sercfg_regs.sv
// Module: serial port control/status register block (top).
// Holds configuration registers, drives the transmit strobe and a
// registered read port; status flags live in sercfg_flags.
// Assumes rd_en and wr_en are never high together and CNT_W <= 8.
module sercfg_regs
    import sercfg_pkg::*;
#(
    parameter bit FIFO_EN = 1'b1,
    parameter int ADDR_W  = 6,
    parameter int CNT_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              ev_brk,
    input  logic              ev_rx_full,
    input  logic              ev_rx_ready,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic              acc_err,
    output logic              tx_strobe,
    output logic [DW-1:0]     tx_byte,
    output logic [DW-1:0]     mode_o,
    output logic [DW-1:0]     rate_o,
    output logic [DW-1:0]     ctrl_o,
    output logic [DW-1:0]     fifo_ctl_o,
    output logic [DW-1:0]     port_o
);

    localparam logic [DW-1:0] MODE_MASK = mode_mask(FIFO_EN);
    localparam logic [DW-1:0] CTRL_MASK = ctrl_mask(FIFO_EN);
    localparam logic [DW-1:0] TXD_RST   = FIFO_EN ? 8'h00 : 8'hFF;

    sel_e          sel;
    flags_t        flags_q;
    flags_t        stat_keep;
    logic          hit;
    logic          wr_ok;
    logic          rd_ok;
    logic [DW-1:0] txd_q;
    logic [DW-1:0] rd_mux;

    sercfg_decode #(.FIFO_EN(FIFO_EN), .ADDR_W(ADDR_W)) u_decode (
        .addr  (addr),
        .is_wr (wr_en),
        .sel   (sel)
    );

    assign hit       = (sel != SEL_NONE);
    assign wr_ok     = wr_en && hit;
    assign rd_ok     = rd_en && !wr_en && hit;
    assign stat_keep = '{tend: wr_data[6], tde: wr_data[5], brk: wr_data[4],
                         rdf: wr_data[1], dr: wr_data[0]};

    sercfg_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_wr       (wr_ok && sel == SEL_CTRL),
        .ctrl_txen_new (wr_data[TXEN_BIT]),
        .txd_wr        (wr_ok && sel == SEL_TXD),
        .stat_wr       (wr_ok && sel == SEL_STAT),
        .stat_keep     (stat_keep),
        .stat_rd       (rd_ok && sel == SEL_STAT),
        .txen          (ctrl_o[TXEN_BIT]),
        .ev_brk        (ev_brk),
        .ev_rdf        (ev_rx_full),
        .ev_dr         (ev_rx_ready),
        .flags_q       (flags_q)
    );

    // Configuration registers: store masked write data on a legal write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o     <= '0;
            rate_o     <= 8'hFF;
            ctrl_o     <= '0;
            txd_q      <= TXD_RST;
            fifo_ctl_o <= '0;
            port_o     <= '0;
        end else if (wr_ok) begin
            case (sel)
                SEL_MODE: mode_o     <= wr_data & MODE_MASK;
                SEL_RATE: rate_o     <= wr_data;
                SEL_CTRL: ctrl_o     <= wr_data & CTRL_MASK;
                SEL_TXD:  txd_q      <= wr_data;
                SEL_FCTL: fifo_ctl_o <= wr_data;
                SEL_PORT: port_o     <= wr_data;
                default:  ;
            endcase
        end
    end

    // Read multiplexer; unmapped selects read all ones
    always_comb begin
        case (sel)
            SEL_MODE: rd_mux = mode_o;
            SEL_RATE: rd_mux = rate_o;
            SEL_CTRL: rd_mux = ctrl_o;
            SEL_TXD:  rd_mux = txd_q;
            SEL_STAT: rd_mux = pack_status(flags_q);
            SEL_FCTL: rd_mux = fifo_ctl_o;
            SEL_RXC:  rd_mux = DW'(rx_count);
            SEL_PORT: rd_mux = port_o;
            SEL_LSR:  rd_mux = '0;
            default:  rd_mux = '1;
        endcase
    end

    // Registered bus responses and transmit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            acc_err   <= 1'b0;
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
        end else begin
            rd_valid  <= rd_en;
            acc_err   <= (rd_en || wr_en) && !hit;
            tx_strobe <= wr_ok && sel == SEL_TXD;
            if (rd_en)                     rd_data <= rd_mux;
            if (wr_ok && sel == SEL_TXD)   tx_byte <= wr_data;
        end
    end

endmodule

// File: rtl/sercfg_chk.sv
// Module: property checker for sercfg_regs, attached by bind.
// Assumes rd_en and wr_en are exclusive, as the block does.
module sercfg_chk
    import sercfg_pkg::*;
#(
    parameter bit FIFO_EN = 1'b1,
    parameter int ADDR_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wr_data,
    input logic              ev_brk,
    input logic              ev_rx_full,
    input logic              ev_rx_ready,
    input logic [DW-1:0]     rd_data,
    input logic              rd_valid,
    input logic              acc_err,
    input logic              tx_strobe,
    input logic [DW-1:0]     tx_byte,
    input logic [DW-1:0]     mode_o,
    input logic [DW-1:0]     rate_o,
    input logic [DW-1:0]     ctrl_o,
    input logic [4:0]        flags
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'('h0C);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h10);

    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R2

    AST_MODE_CTRL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o & ~mode_mask(FIFO_EN)) == '0) && ((ctrl_o & ~ctrl_mask(FIFO_EN)) == '0)); // R3

    AST_TEND_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == A_CTRL && !wr_data[TXEN_BIT]) |=> flags[4]); // R4

    AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == A_TXD) |=> (tx_strobe && tx_byte == $past(wr_data))); // R5

    AST_TDE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == A_TXD) |=> !flags[3]); // R5

    AST_STATUS_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !acc_err && $past(rd_en) && $past(addr) == A_STAT)
        |-> (rd_data[7] == 1'b0 && rd_data[3:2] == 2'b00)); // R6

    AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (FIFO_EN && rd_en && !wr_en && addr == A_STAT && ctrl_o[TXEN_BIT])
        |=> (flags[4] && flags[3])); // R8

    AST_EVENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_brk || ev_rx_full || ev_rx_ready)
        |=> ((!$past(ev_brk) || flags[2]) && (!$past(ev_rx_full) || flags[1])
             && (!$past(ev_rx_ready) || flags[0]))); // R9

    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(rd_en || wr_en)); // R10

    AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> ($stable(mode_o) && $stable(rate_o) && $stable(ctrl_o) && !tx_strobe)); // R10

endmodule

bind sercfg_regs sercfg_chk #(.FIFO_EN(FIFO_EN), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .ev_brk      (ev_brk),
    .ev_rx_full  (ev_rx_full),
    .ev_rx_ready (ev_rx_ready),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .acc_err     (acc_err),
    .tx_strobe   (tx_strobe),
    .tx_byte     (tx_byte),
    .mode_o      (mode_o),
    .rate_o      (rate_o),
    .ctrl_o      (ctrl_o),
    .flags       (flags_q)
);

// File: tb/test_sercfg_regs.sv
// Bench: behavioural reference model of the FIFO variant, compared on
// every clock, plus directed checks on both variants sharing one bus.
module test_sercfg_regs;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int CNT_W      = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wr_data = '0;
    logic [CNT_W-1:0]  rx_count = '0;
    logic              ev_brk = 1'b0;
    logic              ev_rx_full = 1'b0;
    logic              ev_rx_ready = 1'b0;

    logic [7:0] rd_data, tx_byte, mode_o, rate_o, ctrl_o, fifo_ctl_o, port_o;
    logic       rd_valid, acc_err, tx_strobe;
    logic [7:0] nf_rd_data, nf_tx_byte, nf_mode, nf_rate, nf_ctrl, nf_fctl, nf_port;
    logic       nf_rd_valid, nf_acc_err, nf_tx_strobe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sercfg_regs #(.FIFO_EN(1'b1), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_sercfg_regs (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rx_count(rx_count), .ev_brk(ev_brk),
        .ev_rx_full(ev_rx_full), .ev_rx_ready(ev_rx_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .acc_err(acc_err),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .mode_o(mode_o),
        .rate_o(rate_o), .ctrl_o(ctrl_o), .fifo_ctl_o(fifo_ctl_o), .port_o(port_o));

    sercfg_regs #(.FIFO_EN(1'b0), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_sercfg_regs_nf (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rx_count(rx_count), .ev_brk(ev_brk),
        .ev_rx_full(ev_rx_full), .ev_rx_ready(ev_rx_ready),
        .rd_data(nf_rd_data), .rd_valid(nf_rd_valid), .acc_err(nf_acc_err),
        .tx_strobe(nf_tx_strobe), .tx_byte(nf_tx_byte), .mode_o(nf_mode),
        .rate_o(nf_rate), .ctrl_o(nf_ctrl), .fifo_ctl_o(nf_fctl), .port_o(nf_port));

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model (FIFO variant) ----------------
    logic [7:0] m_mode, m_rate, m_ctrl, m_txd, m_fctl, m_port;
    bit         m_tend, m_tde, m_brk, m_rdf, m_dr;
    bit         e_rdv, e_err, e_tx;
    logic [7:0] e_rd, e_txb;
    string      e_tag;
    bit         m_live = 1'b0;

    function automatic bit legal(logic [ADDR_W-1:0] a, bit w);
        if (a[1:0] != 2'b00) return 1'b0;
        case (int'(a))
            'h00, 'h04, 'h08, 'h0C, 'h10, 'h18, 'h20, 'h24: return 1'b1;
            'h1C: return !w;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 8'h00; m_rate = 8'hFF; m_ctrl = 8'h00; m_txd = 8'h00;
            m_fctl = 8'h00; m_port = 8'h00;
            m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0;
            e_rdv = 0; e_err = 0; e_tx = 0; e_rd = 0; e_txb = 0; e_tag = "R1";
            m_live = 1'b1;
        end else begin
            e_rdv = 0; e_err = 0; e_tx = 0;
            if (rd_en || wr_en) begin
                if (!legal(addr, wr_en)) begin
                    e_err = 1;
                    if (rd_en) begin e_rdv = 1; e_rd = 8'hFF; e_tag = "R10"; end
                end else if (wr_en) begin
                    case (int'(addr))
                        'h00: m_mode = wr_data & 8'h7B;
                        'h04: m_rate = wr_data;
                        'h08: begin m_ctrl = wr_data & 8'hFB; if (!wr_data[5]) m_tend = 1; end
                        'h0C: begin m_txd = wr_data; m_tde = 0; e_tx = 1; e_txb = wr_data; end
                        'h10: begin
                            if (!wr_data[6]) m_tend = 0;
                            if (!wr_data[5]) m_tde  = 0;
                            if (!wr_data[4]) m_brk  = 0;
                            if (!wr_data[1]) m_rdf  = 0;
                            if (!wr_data[0]) m_dr   = 0;
                        end
                        'h18: m_fctl = wr_data;
                        'h20: m_port = wr_data;
                        default: ;
                    endcase
                end else begin
                    e_rdv = 1; e_tag = "R2";
                    case (int'(addr))
                        'h00: e_rd = m_mode;
                        'h04: e_rd = m_rate;
                        'h08: e_rd = m_ctrl;
                        'h0C: e_rd = m_txd;
                        'h10: begin
                            e_rd = 8'h00;
                            e_rd[6] = m_tend; e_rd[5] = m_tde; e_rd[4] = m_brk;
                            e_rd[1] = m_rdf;  e_rd[0] = m_dr;
                            e_tag = "R8";
                            if (m_ctrl[5]) begin m_tend = 1; m_tde = 1; end
                        end
                        'h18: e_rd = m_fctl;
                        'h1C: begin e_rd = {3'b000, rx_count}; e_tag = "R11"; end
                        'h20: e_rd = m_port;
                        default: e_rd = 8'h00;
                    endcase
                end
            end
            if (ev_brk)      m_brk = 1;
            if (ev_rx_full)  m_rdf = 1;
            if (ev_rx_ready) m_dr  = 1;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (m_live && !done) begin
            check("R2 rd_valid", int'(rd_valid), int'(e_rdv));
            if (e_rdv) check({e_tag, " rd_data"}, rd_data, e_rd);
            check("R10 acc_err", int'(acc_err), int'(e_err));
            check("R5 tx_strobe", int'(tx_strobe), int'(e_tx));
            if (e_tx) check("R5 tx_byte", tx_byte, e_txb);
            check("R3 mode_o", mode_o, m_mode);
            check("R3 ctrl_o", ctrl_o, m_ctrl);
            check("R2 rate_o", rate_o, m_rate);
            check("R2 fifo_ctl_o", fifo_ctl_o, m_fctl);
            check("R2 port_o", port_o, m_port);
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(bit r, bit w, int a, int d, bit eb, bit ef, bit er);
        @(negedge clk);
        rd_en = r; wr_en = w; addr = ADDR_W'(a); wr_data = 8'(d);
        ev_brk = eb; ev_rx_full = ef; ev_rx_ready = er;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(int a, int d);
        drive(0, 1, a, d, 0, 0, 0);
        idle();
    endtask

    // Read; after return, outputs for that read are visible
    task automatic rd(int a);
        drive(1, 0, a, 0, 0, 0, 0);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        check("R1 mode reset", mode_o, 8'h00);
        check("R1 rate reset", rate_o, 8'hFF);
        check("R1 ctrl reset", ctrl_o, 8'h00);
        check("R1 port reset", port_o, 8'h00);
        check("R1 fifo ctl reset", fifo_ctl_o, 8'h00);
        rd('h0C);
        check("R1 txd reset fifo", rd_data, 8'h00);
        check("R1 txd reset nofifo", nf_rd_data, 8'hFF);
        rd('h10);
        check("R1 status reset", rd_data, 8'h60);

        wr('h10, 'hBF); rd('h10);
        check("R7 clear tend only", rd_data, 8'h20);

        wr('h10, 'h00); wr('h08, 'h00); rd('h10);
        check("R4 ctrl write sets tend", rd_data, 8'h40);

        drive(0, 0, 0, 0, 1, 0, 1); idle(); rd('h10);
        check("R9 event set", rd_data, 8'h51);
        drive(0, 1, 'h10, 'h00, 0, 1, 0); idle(); rd('h10);
        check("R9 set beats clear", rd_data, 8'h02);

        wr('h08, 'h20); rd('h10);
        check("R8 read returns pre-read", rd_data, 8'h02);
        rd('h10);
        check("R8 rearm after read", rd_data, 8'h62);

        drive(0, 1, 'h0C, 'h5A, 0, 0, 0); idle();
        check("R5 strobe", int'(tx_strobe), 1);
        check("R5 byte", tx_byte, 8'h5A);
        idle();
        check("R5 strobe one cycle", int'(tx_strobe), 0);
        rd('h0C);
        check("R5 txd readback", rd_data, 8'h5A);
        rd('h10);
        check("R5 tde cleared", rd_data, 8'h42);
        check("R6 zero bits", rd_data & 8'h8C, 0);

        wr('h00, 'hFF);
        check("R3 mode mask fifo", mode_o, 8'h7B);
        check("R3 mode nofifo", nf_mode, 8'hFF);
        wr('h08, 'hFF);
        check("R3 ctrl mask fifo", ctrl_o, 8'hFB);
        check("R3 ctrl nofifo", nf_ctrl, 8'hFF);

        wr('h20, 'h3C); rd('h20);
        check("R2 port readback", rd_data, 8'h3C);
        wr('h24, 'h77); rd('h24);
        check("R2 line status zero", rd_data, 8'h00);
        wr('h04, 'h11);
        check("R2 rate write", rate_o, 8'h11);

        rx_count = 5'd13; rd('h1C);
        check("R11 rx count", rd_data, 13);

        drive(1, 0, 'h14, 0, 0, 0, 0); idle();
        check("R10 hole err", int'(acc_err), 1);
        check("R10 hole data", rd_data, 8'hFF);
        drive(0, 1, 'h28, 'h00, 0, 0, 0); idle();
        check("R10 outside err", int'(acc_err), 1);
        check("R10 outside keeps mode", mode_o, 8'h7B);
        drive(0, 1, 'h1C, 'h00, 0, 0, 0); idle();
        check("R10 rx count write err", int'(acc_err), 1);
        drive(0, 1, 'h05, 'h00, 0, 0, 0); idle();
        check("R10 misaligned err", int'(acc_err), 1);
        check("R10 misaligned keeps rate", rate_o, 8'h11);
        rd('h10);
        check("R10 nofifo status err", int'(nf_acc_err), 1);
        check("R10 nofifo status data", nf_rd_data, 8'hFF);

        // Random traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            int pick = $urandom_range(0, 13);
            int offs[14] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h10, 'h18, 'h1C,
                             'h20, 'h24, 'h14, 'h28, 'h3C, 'h02};
            int op = $urandom_range(0, 2);
            rx_count = CNT_W'($urandom);
            drive(op == 1, op == 2, offs[pick], $urandom_range(0, 255),
                  $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
                  $urandom_range(0, 9) == 0);
        end
        idle(); idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule